// File: doc/BRIEF.md
# PCIe Host Bridge Request Decoder

This block takes load and store requests from the hart side and routes each one by its address. A request that lands in the configuration aperture becomes a configuration read or write on the root bus. The aperture offset is split into bus, device, function and register fields. A request that lands in one of the programmed outbound memory windows goes downstream as a memory request, and its address is not changed. Any other address is answered locally with an error and never reaches the root bus.

The block handles one request at a time. It does not answer the hart until the downstream completion has come back, except for a locally generated error. The completion status decides the reply. A failed configuration read returns all ones and no error, which is how software probes for absent functions. A memory access that fails, or one whose address matched nothing, returns an error. The aperture and the windows are set through base/limit inputs, and both bounds are inclusive.

Top module: `pcie_hb_decoder`

## Requirements
- R1: After reset, h_req_ready is 1, while d_req_valid and h_rsp_valid are both 0.
- R2: An access with cfg_base <= address <= cfg_limit is issued downstream with d_req_kind = 1 (configuration), and d_req_we is equal to the hart's write flag.
- R3: For a configuration request, let off = address - cfg_base. Then d_req_bus = off[27:20], d_req_dev = off[19:15], d_req_fn = off[14:12] and d_req_reg = off[11:0].
- R4: An access that falls outside the configuration aperture but inside an outbound window i (win_base slice i <= address <= win_limit slice i, where slice i is bits [i*32 +: 32]) is issued with d_req_kind = 0 (memory). d_req_addr equals the hart address, and the write data and byte enables are passed through.
- R5: An access that hits no window is answered one cycle after it is accepted, with h_rsp_err = 1 and h_rsp_rdata = 0, and no downstream request is made.
- R6: A configuration read whose completion status is 1 (unsupported request) or 2 (no such device/function) is answered with h_rsp_err = 0 and h_rsp_rdata all ones.
- R7: Completion status 0 (success) gives h_rsp_err = 0, with the completion data on reads and 0 on writes. Status 3 (abort) on any access, or any non-zero status on a memory access, gives h_rsp_err = 1 with data 0. A configuration write with status 1 or 2 gives h_rsp_err = 0.
- R8: A window matches with both bounds inclusive. A window whose limit is below its base matches no address.
- R9: When an address lies in both the configuration aperture and an outbound window, the configuration aperture wins.
- R10: Only one request is in flight. h_req_ready stays 0 from acceptance until after the one-cycle h_rsp_valid pulse, and that pulse comes in the cycle after the completion is taken.
- R11: While d_req_valid is 1 and d_req_ready is 0, d_req_valid stays 1 and the request fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | Configuration aperture lowest address |
| cfg_limit | input | 32 | Configuration aperture highest address |
| win_base | input | 64 | Outbound window bases, 32 bits per window |
| win_limit | input | 64 | Outbound window limits, 32 bits per window |
| h_req_valid | input | 1 | Hart request valid |
| h_req_ready | output | 1 | Hart request accepted this cycle |
| h_req_addr | input | 32 | Hart system address |
| h_req_we | input | 1 | 1 = write, 0 = read |
| h_req_wdata | input | 32 | Write data |
| h_req_be | input | 4 | Byte enables |
| h_rsp_valid | output | 1 | One-cycle response strobe |
| h_rsp_err | output | 1 | Response is an error |
| h_rsp_rdata | output | 32 | Read data of the response |
| d_req_valid | output | 1 | Downstream request valid |
| d_req_ready | input | 1 | Downstream request taken |
| d_req_kind | output | 1 | 1 = configuration, 0 = memory |
| d_req_we | output | 1 | Downstream write flag |
| d_req_addr | output | 32 | Untranslated system address |
| d_req_bus | output | 8 | Configuration bus number |
| d_req_dev | output | 5 | Configuration device number |
| d_req_fn | output | 3 | Configuration function number |
| d_req_reg | output | 12 | Configuration register byte offset |
| d_req_wdata | output | 32 | Downstream write data |
| d_req_be | output | 4 | Downstream byte enables |
| d_cpl_valid | input | 1 | Completion valid |
| d_cpl_status | input | 2 | 0 success, 1 unsupported, 2 no device, 3 abort |
| d_cpl_rdata | input | 32 | Completion data |

## Verification
A fault in the address classification shows up on the cycle right after acceptance. Either a downstream request appears where an immediate error was expected, or the reverse, and d_req_kind reads wrong. A corrupted captured context shows up in the same cycle in the bus/device/function/register or address fields. A completion-mapping fault is seen one cycle after the completion is given, as a wrong error flag or as data other than all ones. A sequencer stuck in some state is seen as h_req_ready or h_rsp_valid holding the wrong level within one or two cycles.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
    localparam int CFG_OFF_W = 28;

    localparam logic KIND_MEM = 1'b0;
    localparam logic KIND_CFG = 1'b1;

    localparam logic [1:0] CPL_OK    = 2'd0;
    localparam logic [1:0] CPL_UNSUP = 2'd1;
    localparam logic [1:0] CPL_NODEV = 2'd2;
    localparam logic [1:0] CPL_ABORT = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } hbd_state_e;
endpackage

// File: rtl/hbd_range_hit.sv
module hbd_range_hit #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic          hit
);
    // An inverted range (hi < lo) fails one of the two compares for every address
    always_comb begin
        hit = (addr >= lo) && (addr <= hi);
    end
endmodule

// File: rtl/hbd_bdf_split.sv
module hbd_bdf_split
    import hbd_pkg::*;
(
    input  logic [CFG_OFF_W-1:0] addr_lo,
    input  logic [CFG_OFF_W-1:0] base_lo,
    output logic [7:0]           bus,
    output logic [4:0]           dev,
    output logic [2:0]           fn,
    output logic [11:0]          reg_off
);
    logic [CFG_OFF_W-1:0] off;

    always_comb begin
        off     = addr_lo - base_lo;
        bus     = off[27:20];
        dev     = off[19:15];
        fn      = off[14:12];
        reg_off = off[11:0];
    end
endmodule

// File: rtl/hbd_target_pick.sv
module hbd_target_pick #(
    parameter int NUM_WIN = 2
) (
    input  logic               cfg_hit,
    input  logic [NUM_WIN-1:0] win_hit,
    output logic               go_cfg,
    output logic               go_mem,
    output logic               go_err
);
    logic any_win;

    always_comb begin
        any_win = |win_hit;
        go_cfg  = cfg_hit;
        go_mem  = !cfg_hit && any_win;
        go_err  = !cfg_hit && !any_win;
    end
endmodule

// File: rtl/pcie_hb_decoder.sv
module pcie_hb_decoder
    import hbd_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int NUM_WIN = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         cfg_base,
    input  logic [AW-1:0]         cfg_limit,
    input  logic [NUM_WIN*AW-1:0] win_base,
    input  logic [NUM_WIN*AW-1:0] win_limit,
    input  logic                  h_req_valid,
    output logic                  h_req_ready,
    input  logic [AW-1:0]         h_req_addr,
    input  logic                  h_req_we,
    input  logic [DW-1:0]         h_req_wdata,
    input  logic [DW/8-1:0]       h_req_be,
    output logic                  h_rsp_valid,
    output logic                  h_rsp_err,
    output logic [DW-1:0]         h_rsp_rdata,
    output logic                  d_req_valid,
    input  logic                  d_req_ready,
    output logic                  d_req_kind,
    output logic                  d_req_we,
    output logic [AW-1:0]         d_req_addr,
    output logic [7:0]            d_req_bus,
    output logic [4:0]            d_req_dev,
    output logic [2:0]            d_req_fn,
    output logic [11:0]           d_req_reg,
    output logic [DW-1:0]         d_req_wdata,
    output logic [DW/8-1:0]       d_req_be,
    input  logic                  d_cpl_valid,
    input  logic [1:0]            d_cpl_status,
    input  logic [DW-1:0]         d_cpl_rdata
);
    localparam int BW = DW / 8;

    typedef struct packed {
        hbd_state_e     st;
        logic           kind;
        logic           we;
        logic [AW-1:0]  addr;
        logic [7:0]     bus;
        logic [4:0]     dev;
        logic [2:0]     fn;
        logic [11:0]    reg_off;
        logic [DW-1:0]  wdata;
        logic [BW-1:0]  be;
        logic           rsp_err;
        logic [DW-1:0]  rsp_data;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    // ---------------- address classification ----------------
    logic               cfg_hit;
    logic [NUM_WIN-1:0] win_hit;
    logic               go_cfg, go_mem, go_err;
    logic [7:0]         dec_bus;
    logic [4:0]         dec_dev;
    logic [2:0]         dec_fn;
    logic [11:0]        dec_reg;

    hbd_range_hit #(.AW(AW)) u_cfg_hit (
        .addr (h_req_addr),
        .lo   (cfg_base),
        .hi   (cfg_limit),
        .hit  (cfg_hit)
    );

    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
        hbd_range_hit #(.AW(AW)) u_win_hit (
            .addr (h_req_addr),
            .lo   (win_base[gi*AW +: AW]),
            .hi   (win_limit[gi*AW +: AW]),
            .hit  (win_hit[gi])
        );
    end

    hbd_target_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .cfg_hit (cfg_hit),
        .win_hit (win_hit),
        .go_cfg  (go_cfg),
        .go_mem  (go_mem),
        .go_err  (go_err)
    );

    hbd_bdf_split u_bdf (
        .addr_lo (h_req_addr[CFG_OFF_W-1:0]),
        .base_lo (cfg_base[CFG_OFF_W-1:0]),
        .bus     (dec_bus),
        .dev     (dec_dev),
        .fn      (dec_fn),
        .reg_off (dec_reg)
    );

    // ---------------- next-state computation ----------------
    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (h_req_valid) begin
                    ctx_d.we       = h_req_we;
                    ctx_d.addr     = h_req_addr;
                    ctx_d.bus      = dec_bus;
                    ctx_d.dev      = dec_dev;
                    ctx_d.fn       = dec_fn;
                    ctx_d.reg_off  = dec_reg;
                    ctx_d.wdata    = h_req_wdata;
                    ctx_d.be       = h_req_be;
                    ctx_d.kind     = go_cfg ? KIND_CFG : KIND_MEM;
                    ctx_d.rsp_err  = 1'b0;
                    ctx_d.rsp_data = '0;
                    if (go_err) begin
                        ctx_d.st      = ST_RESP;
                        ctx_d.rsp_err = 1'b1;
                    end else if (go_cfg || go_mem) begin
                        ctx_d.st = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (d_req_ready) begin
                    ctx_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (d_cpl_valid) begin
                    ctx_d.st       = ST_RESP;
                    ctx_d.rsp_err  = 1'b0;
                    ctx_d.rsp_data = '0;
                    if (d_cpl_status == CPL_OK) begin
                        if (!ctx_q.we) ctx_d.rsp_data = d_cpl_rdata;
                    end else if (ctx_q.kind == KIND_CFG &&
                                 (d_cpl_status == CPL_UNSUP || d_cpl_status == CPL_NODEV)) begin
                        if (!ctx_q.we) ctx_d.rsp_data = '1;
                    end else begin
                        ctx_d.rsp_err = 1'b1;
                    end
                end
            end
            ST_RESP: begin
                ctx_d.st = ST_IDLE;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= ctx_t'('0);
        end else begin
            ctx_q <= ctx_d;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        h_req_ready = (ctx_q.st == ST_IDLE);
        h_rsp_valid = (ctx_q.st == ST_RESP);
        h_rsp_err   = ctx_q.rsp_err;
        h_rsp_rdata = ctx_q.rsp_data;
        d_req_valid = (ctx_q.st == ST_ISSUE);
        d_req_kind  = ctx_q.kind;
        d_req_we    = ctx_q.we;
        d_req_addr  = ctx_q.addr;
        d_req_bus   = ctx_q.bus;
        d_req_dev   = ctx_q.dev;
        d_req_fn    = ctx_q.fn;
        d_req_reg   = ctx_q.reg_off;
        d_req_wdata = ctx_q.wdata;
        d_req_be    = ctx_q.be;
    end

    // ---------------- assertions ----------------
    // R2
    cfg_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req_valid && h_req_ready && go_cfg) |=>
            (d_req_valid && d_req_kind == KIND_CFG && d_req_we == $past(h_req_we)));

    // R5
    miss_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req_valid && h_req_ready && go_err) |=>
            (h_rsp_valid && h_rsp_err && !d_req_valid));

    // R6
    cfg_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_cpl_valid && ctx_q.st == ST_WAIT && ctx_q.kind == KIND_CFG && !ctx_q.we &&
         (d_cpl_status == CPL_UNSUP || d_cpl_status == CPL_NODEV)) |=>
            (h_rsp_valid && !h_rsp_err && (&h_rsp_rdata)));

    // R10
    one_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_req_valid |-> (!h_req_ready && !h_rsp_valid));

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_rsp_valid |=> !h_rsp_valid);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req_valid && !d_req_ready) |=>
            (d_req_valid && $stable(d_req_addr) && $stable(d_req_kind) && $stable(d_req_we)));
endmodule

// File: tb/sim_pcie_hb_decoder.sv
module sim_pcie_hb_decoder;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [AW-1:0]    cfg_base = 32'h3000_0000, cfg_limit = 32'h3FFF_FFFF;
    logic [NW*AW-1:0] win_base  = {32'h8000_0000, 32'h4000_0000};
    logic [NW*AW-1:0] win_limit = {32'h8FFF_FFFF, 32'h4FFF_FFFF};
    logic             h_req_valid = 1'b0, h_req_we = 1'b0;
    logic [AW-1:0]    h_req_addr = '0;
    logic [DW-1:0]    h_req_wdata = '0;
    logic [3:0]       h_req_be = '0;
    logic             d_req_ready = 1'b0, d_cpl_valid = 1'b0;
    logic [1:0]       d_cpl_status = 2'd0;
    logic [DW-1:0]    d_cpl_rdata = '0;
    logic             h_req_ready, h_rsp_valid, h_rsp_err;
    logic [DW-1:0]    h_rsp_rdata;
    logic             d_req_valid, d_req_kind, d_req_we;
    logic [AW-1:0]    d_req_addr;
    logic [7:0]       d_req_bus;
    logic [4:0]       d_req_dev;
    logic [2:0]       d_req_fn;
    logic [11:0]      d_req_reg;
    logic [DW-1:0]    d_req_wdata;
    logic [3:0]       d_req_be;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    pcie_hb_decoder u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .win_base(win_base), .win_limit(win_limit),
        .h_req_valid(h_req_valid), .h_req_ready(h_req_ready),
        .h_req_addr(h_req_addr), .h_req_we(h_req_we),
        .h_req_wdata(h_req_wdata), .h_req_be(h_req_be),
        .h_rsp_valid(h_rsp_valid), .h_rsp_err(h_rsp_err), .h_rsp_rdata(h_rsp_rdata),
        .d_req_valid(d_req_valid), .d_req_ready(d_req_ready),
        .d_req_kind(d_req_kind), .d_req_we(d_req_we), .d_req_addr(d_req_addr),
        .d_req_bus(d_req_bus), .d_req_dev(d_req_dev), .d_req_fn(d_req_fn),
        .d_req_reg(d_req_reg), .d_req_wdata(d_req_wdata), .d_req_be(d_req_be),
        .d_cpl_valid(d_cpl_valid), .d_cpl_status(d_cpl_status), .d_cpl_rdata(d_cpl_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit in_rng(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    // class: 0 = miss, 1 = config, 2 = memory (R2, R4, R8, R9)
    function automatic int classify(input logic [31:0] a);
        if (in_rng(a, cfg_base, cfg_limit)) return 1;
        for (int i = 0; i < NW; i++)
            if (in_rng(a, win_base[i*32 +: 32], win_limit[i*32 +: 32])) return 2;
        return 0;
    endfunction

    task automatic access(input logic [31:0] a, input bit we, input logic [31:0] wd,
                          input logic [3:0] be, input logic [1:0] st, input logic [31:0] cd);
        int cls;
        logic [31:0] off;
        logic [31:0] exp_data;
        bit exp_err;
        cls = classify(a);
        off = a - cfg_base;
        @(negedge clk);
        h_req_valid = 1'b1; h_req_addr = a; h_req_we = we; h_req_wdata = wd; h_req_be = be;
        while (!h_req_ready) @(negedge clk);
        @(negedge clk);
        h_req_valid = 1'b0;
        if (cls == 0) begin
            chk(h_rsp_valid && h_rsp_err, "R5 miss error", {h_rsp_valid, h_rsp_err}, 2'b11);
            chk(h_rsp_rdata == 0, "R5 miss data", h_rsp_rdata, 0);
            chk(!d_req_valid, "R5 no downstream", d_req_valid, 0);
            @(negedge clk);
            chk(!h_rsp_valid && h_req_ready, "R10 back to idle", {h_rsp_valid, h_req_ready}, 2'b01);
            return;
        end
        chk(d_req_valid, "R2/R4 request issued", d_req_valid, 1);
        chk(d_req_we == we, "R2 direction", d_req_we, we);
        if (cls == 1) begin
            chk(d_req_kind == 1'b1, "R2 config kind", d_req_kind, 1);
            chk(d_req_bus == off[27:20], "R3 bus", d_req_bus, off[27:20]);
            chk(d_req_dev == off[19:15], "R3 dev", d_req_dev, off[19:15]);
            chk(d_req_fn == off[14:12], "R3 fn", d_req_fn, off[14:12]);
            chk(d_req_reg == off[11:0], "R3 reg", d_req_reg, off[11:0]);
        end else begin
            chk(d_req_kind == 1'b0, "R4 memory kind", d_req_kind, 0);
            chk(d_req_addr == a, "R4 address passthrough", d_req_addr, a);
            if (we) begin
                chk(d_req_wdata == wd, "R4 wdata", d_req_wdata, wd);
                chk(d_req_be == be, "R4 byte enables", d_req_be, be);
            end
        end
        chk(!h_req_ready && !h_rsp_valid, "R10 busy while issuing", {h_req_ready, h_rsp_valid}, 0);
        @(negedge clk);
        chk(d_req_valid && d_req_addr == a, "R11 request held", d_req_addr, a);
        d_req_ready = 1'b1;
        @(negedge clk);
        d_req_ready = 1'b0;
        chk(!d_req_valid && !h_rsp_valid && !h_req_ready, "R10 waiting for completion",
            {d_req_valid, h_rsp_valid, h_req_ready}, 0);
        d_cpl_valid = 1'b1; d_cpl_status = st; d_cpl_rdata = cd;
        @(negedge clk);
        d_cpl_valid = 1'b0;
        exp_err = 1'b0;
        exp_data = 32'h0;
        if (st == 2'd0) begin
            if (!we) exp_data = cd;
        end else if (cls == 1 && (st == 2'd1 || st == 2'd2)) begin
            if (!we) exp_data = 32'hFFFF_FFFF;
        end else begin
            exp_err = 1'b1;
        end
        chk(h_rsp_valid, "R10 response after completion", h_rsp_valid, 1);
        if (cls == 1 && !we && (st == 2'd1 || st == 2'd2))
            chk(!h_rsp_err && h_rsp_rdata == exp_data, "R6 all-ones config read",
                {h_rsp_err, h_rsp_rdata}, {1'b0, exp_data});
        else
            chk(h_rsp_err == exp_err && h_rsp_rdata == exp_data, "R7 completion mapping",
                {h_rsp_err, h_rsp_rdata}, {exp_err, exp_data});
        @(negedge clk);
        chk(!h_rsp_valid && h_req_ready, "R10 single pulse", {h_rsp_valid, h_req_ready}, 2'b01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(h_req_ready && !d_req_valid && !h_rsp_valid, "R1 reset state",
            {h_req_ready, d_req_valid, h_rsp_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(h_req_ready && !d_req_valid && !h_rsp_valid, "R1 after release",
            {h_req_ready, d_req_valid, h_rsp_valid}, 3'b100);

        // coarse sweep over all 16 regions, both directions (R2, R4, R5, R8)
        for (int r = 0; r < 16; r++) begin
            for (int v = 0; v < 3; v++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [31:0] a;
                    a = {r[3:0], 28'h0} | (v == 0 ? 32'h0 : (v == 1 ? 32'h4 : 32'h0FFF_FFFC));
                    access(a, w[0], a ^ 32'hC3C3_0000, 4'b1010, 2'd0, a ^ 32'h5A5A_5A5A);
                end
            end
        end

        // bus/device/function sweep with config reads (R3, R6, R7)
        for (int b = 0; b < 3; b++) begin
            for (int d = 0; d < 32; d++) begin
                for (int f = 0; f < 2; f++) begin
                    for (int g = 0; g < 2; g++) begin
                        logic [7:0] bus;
                        logic [31:0] a;
                        logic [1:0] st;
                        bus = (b == 0) ? 8'd0 : ((b == 1) ? 8'd1 : 8'd255);
                        a = cfg_base + {4'h0, bus, d[4:0], (f == 0 ? 3'd0 : 3'd7),
                                        (g == 0 ? 12'h000 : 12'hFFC)};
                        st = (d < 8) ? 2'd0 : ((bus == 0) ? 2'd2 : 2'd1);
                        access(a, 1'b0, 32'h0, 4'hF, st, {bus, d[7:0], 16'hBEEF});
                    end
                end
            end
        end

        // R7 status corner cases
        access(32'h4000_1000, 1'b0, 0, 4'hF, 2'd1, 32'h1234_5678);
        access(32'h4000_1000, 1'b1, 32'h11, 4'h1, 2'd1, 0);
        access(32'h8000_2000, 1'b0, 0, 4'hF, 2'd3, 32'hAAAA_AAAA);
        access(32'h3000_8000, 1'b1, 32'h22, 4'h3, 2'd1, 0);
        access(32'h3000_8000, 1'b1, 32'h22, 4'h3, 2'd2, 0);
        access(32'h3000_8000, 1'b0, 0, 4'hF, 2'd3, 32'h7777_7777);

        // R8 inverted window and inclusive bounds
        win_base  = {32'h9000_0000, 32'h5000_0000};
        win_limit = {32'h8000_0000, 32'h5000_0FFF};
        @(negedge clk);
        access(32'h8800_0000, 1'b0, 0, 4'hF, 2'd0, 32'h1);
        access(32'h9000_0000, 1'b0, 0, 4'hF, 2'd0, 32'h2);
        access(32'h4FFF_FFFC, 1'b0, 0, 4'hF, 2'd0, 32'h3);
        access(32'h5000_0000, 1'b0, 0, 4'hF, 2'd0, 32'h4);
        access(32'h5000_0FFF, 1'b1, 32'h9, 4'h8, 2'd0, 0);
        access(32'h5000_1000, 1'b0, 0, 4'hF, 2'd0, 32'h5);

        // R9 configuration aperture wins over an overlapping window
        win_base  = {32'h9000_0000, 32'h3000_0000};
        win_limit = {32'h8000_0000, 32'h3FFF_FFFF};
        @(negedge clk);
        access(32'h3000_0000, 1'b0, 0, 4'hF, 2'd0, 32'h66);
        @(negedge clk);
        chk(1'b1, "R9 overlap exercised", 0, 0);
        access(32'h3FFF_FFFC, 1'b1, 32'h77, 4'hF, 2'd0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule